// File: doc/BRIEF.md
# High-Speed Burst Sequencer for One Data Lane

This block is the transmit-side controller of a single differential data lane that alternates between a low-power signalling mode and a high-speed mode. While the lane is idle it holds the stop level. A burst request is honoured only when the associated clock lane reports that its high-speed clock is running. The block then walks the lane through the start-of-transmission states:

- a request level;
- a bridge level with both wires low;
- a high-speed zero period;
- one sync byte.

After that it streams payload bytes taken from a valid/ready source. When the byte flagged as last has been sent, the lane drives a trail pattern and then returns to the stop level. The trail pattern is the inverse of the final payload bit.

Every interval is a programmable count of clock cycles. The block works on whole bytes: one byte per cycle is handed to a downstream serializer, which sends bit 0 first. Re-entering the stop level raises a one-cycle completion pulse. The clock lane sequencer uses that pulse to time how long its clock keeps running after the data lane has gone quiet.

Top module: `hsl_lane_seq`

## Requirements
- R1: During and after reset, and until a burst starts, the lane is at LP-11 (`lp_dp`=1, `lp_dn`=1). In that state `hs_en`=0, `hs_data`=0, `tx_ready`=0 and `burst_done`=0. Whenever `hs_en` is 0, `hs_data` is 0.
- R2: While the lane is in stop, `burst_req` is ignored for as long as `clk_ready` is low, and the lane stays at LP-11.
- R3: `burst_req` and `clk_ready` may both be sampled high at a clock edge while the lane is in stop. The lane then shows LP-01 (`lp_dp`=0, `lp_dn`=1) from the next cycle, for `t_lpx` cycles.
- R4: LP-01 is followed by LP-00 (both wires 0, `hs_en`=0) for `t_prep` cycles.
- R5: LP-00 is followed by `t_zero` cycles with `hs_en`=1 and `hs_data`=8'h00. The LP wires stay 0 whenever `hs_en` is 1.
- R6: After the zero period, exactly one cycle carries the sync byte 8'hB8 on `hs_data`. Bit 0 is the first bit on the wire.
- R7: `tx_ready` is high in the sync cycle, and in every payload cycle until the byte flagged `tx_last` has been accepted. It is low at all other times. A byte accepted at a clock edge appears on `hs_data` in the following cycle, and bytes appear in acceptance order. The source must keep `tx_valid` high from the sync cycle onward.
- R8: The last payload byte is followed by `t_trail` cycles of the trail. In each trail cycle all eight bits of `hs_data` equal the inverse of bit 7 of that last byte.
- R9: The cycle after the trail ends, the lane is back at LP-11 with `hs_en`=0. `burst_done` is high for exactly that one cycle.
- R10: LP-11 is held for `t_exit` cycles after the trail. Requests are ignored during that time, and at least one further stop cycle passes before the next LP-01.
- R11: A programmed interval of 0 behaves as an interval of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_lpx | input | CNT_W | LP-01 request length in cycles |
| t_prep | input | CNT_W | LP-00 bridge length in cycles |
| t_zero | input | CNT_W | High-speed zero length in cycles |
| t_trail | input | CNT_W | Trail length in cycles |
| t_exit | input | CNT_W | Minimum LP-11 hold after a burst in cycles |
| clk_ready | input | 1 | Clock lane is running high-speed |
| burst_req | input | 1 | Request to start a burst |
| tx_data | input | 8 | Payload byte |
| tx_valid | input | 1 | Payload byte is valid |
| tx_last | input | 1 | Payload byte is the last of the burst |
| tx_ready | output | 1 | Lane accepts a payload byte this cycle |
| lp_dp | output | 1 | Low-power level of the positive wire |
| lp_dn | output | 1 | Low-power level of the negative wire |
| hs_en | output | 1 | High-speed driver enabled |
| hs_data | output | 8 | Byte for the serializer, bit 0 first |
| burst_done | output | 1 | One-cycle pulse on return to stop |

## Verification
Several properties are checked on every cycle:

- Ready is never offered outside high-speed mode.
- The LP wires are low whenever high-speed is on.
- High-speed mode is only entered straight from LP-00.
- The completion pulse lasts one cycle and coincides with LP-11.
- The last high-speed byte before leaving is a uniform trail pattern.
- A stop lane never starts without the clock lane being ready.

The exact interval lengths, the sync byte and the payload order are shown only by the bench's reference model, which compares every output on every cycle. So are the polarity of the trail relative to the last bit, the treatment of zero counts and the refusal of requests during the exit hold.

// File: rtl/hsl_pkg.sv
`timescale 1ns/1ps
package hsl_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_PATTERN = 8'hB8;

    typedef enum logic [2:0] {
        PH_STOP,
        PH_REQ,
        PH_PREP,
        PH_ZERO,
        PH_SYNC,
        PH_DATA,
        PH_TRAIL,
        PH_EXIT
    } hsl_phase_e;

    typedef struct packed {
        hsl_phase_e        ph;
        logic [BYTE_W-1:0] held;
        logic              last_seen;
        logic              done;
    } hsl_ctl_t;

endpackage

// File: rtl/hsl_phase_timer.sv
`timescale 1ns/1ps
module hsl_phase_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    // A length of N keeps the phase for N cycles; 0 counts as 1.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (len == '0) ? '0 : len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/hsl_line_enc.sv
`timescale 1ns/1ps
module hsl_line_enc
    import hsl_pkg::*;
(
    input  hsl_phase_e        ph,
    input  logic [BYTE_W-1:0] held,
    output logic              dp,
    output logic              dn,
    output logic              hs,
    output logic [BYTE_W-1:0] hs_byte
);

    always_comb begin
        dp = 1'b0;
        dn = 1'b0;
        hs = 1'b0;
        unique case (ph)
            PH_STOP, PH_EXIT: begin dp = 1'b1; dn = 1'b1; end
            PH_REQ:           begin dp = 1'b0; dn = 1'b1; end
            PH_PREP:          begin dp = 1'b0; dn = 1'b0; end
            default:          hs = 1'b1;
        endcase
        hs_byte = hs ? held : '0;
    end

endmodule

// File: rtl/hsl_lane_seq.sv
`timescale 1ns/1ps
module hsl_lane_seq
    import hsl_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] t_lpx,
    input  logic [CNT_W-1:0] t_prep,
    input  logic [CNT_W-1:0] t_zero,
    input  logic [CNT_W-1:0] t_trail,
    input  logic [CNT_W-1:0] t_exit,
    input  logic             clk_ready,
    input  logic             burst_req,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    input  logic             tx_last,
    output logic             tx_ready,
    output logic             lp_dp,
    output logic             lp_dn,
    output logic             hs_en,
    output logic [7:0]       hs_data,
    output logic             burst_done
);

    hsl_ctl_t         s_d, s_q;
    logic             t_load;
    logic [CNT_W-1:0] t_len;
    logic             t_exp;
    logic             take;

    hsl_phase_timer #(.CW(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .len     (t_len),
        .expired (t_exp)
    );

    always_comb begin
        s_d    = s_q;
        s_d.done = 1'b0;
        t_load = 1'b0;
        t_len  = '0;

        tx_ready = ((s_q.ph == PH_SYNC) || (s_q.ph == PH_DATA)) && !s_q.last_seen;
        take     = tx_ready && tx_valid;
        if (take) begin
            s_d.held      = tx_data;
            s_d.last_seen = tx_last;
        end

        unique case (s_q.ph)
            PH_STOP: if (burst_req && clk_ready) begin
                s_d.ph = PH_REQ;
                t_load = 1'b1;
                t_len  = t_lpx;
            end
            PH_REQ: if (t_exp) begin
                s_d.ph = PH_PREP;
                t_load = 1'b1;
                t_len  = t_prep;
            end
            PH_PREP: if (t_exp) begin
                s_d.ph   = PH_ZERO;
                s_d.held = '0;
                t_load   = 1'b1;
                t_len    = t_zero;
            end
            PH_ZERO: if (t_exp) begin
                s_d.ph   = PH_SYNC;
                s_d.held = SYNC_PATTERN;
            end
            PH_SYNC: s_d.ph = PH_DATA;
            PH_DATA: if (s_q.last_seen) begin
                s_d.ph        = PH_TRAIL;
                s_d.held      = {BYTE_W{~s_q.held[BYTE_W-1]}};
                s_d.last_seen = 1'b0;
                t_load        = 1'b1;
                t_len         = t_trail;
            end
            PH_TRAIL: if (t_exp) begin
                s_d.ph   = PH_EXIT;
                s_d.held = '0;
                s_d.done = 1'b1;
                t_load   = 1'b1;
                t_len    = t_exit;
            end
            PH_EXIT: if (t_exp) s_d.ph = PH_STOP;
            default: s_d.ph = PH_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_STOP, held: '0, last_seen: 1'b0, done: 1'b0};
        else        s_q <= s_d;
    end

    hsl_line_enc i_enc (
        .ph      (s_q.ph),
        .held    (s_q.held),
        .dp      (lp_dp),
        .dn      (lp_dn),
        .hs      (hs_en),
        .hs_byte (hs_data)
    );

    assign burst_done = s_q.done;

endmodule

// File: rtl/hsl_lane_seq_chk.sv
`timescale 1ns/1ps
module hsl_lane_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_ready,
    input logic       tx_ready,
    input logic       lp_dp,
    input logic       lp_dn,
    input logic       hs_en,
    input logic [7:0] hs_data,
    input logic       burst_done
);

    a_r1_quiet_when_lp: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_en |-> (hs_data == 8'h00));

    a_r2_no_start_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_dp && lp_dn && !clk_ready) |=> lp_dp);

    a_r4_hs_from_bridge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(!lp_dp && !lp_dn));

    a_r5_lp_low_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (!lp_dp && !lp_dn));

    a_r7_ready_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> hs_en);

    a_r8_trail_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_en) |-> ($past(hs_data) == 8'h00 || $past(hs_data) == 8'hFF));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    a_r9_done_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (lp_dp && lp_dn && !hs_en));

endmodule

bind hsl_lane_seq hsl_lane_seq_chk i_hsl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_ready  (clk_ready),
    .tx_ready   (tx_ready),
    .lp_dp      (lp_dp),
    .lp_dn      (lp_dn),
    .hs_en      (hs_en),
    .hs_data    (hs_data),
    .burst_done (burst_done)
);

// File: tb/test_hsl_lane_seq.sv
`timescale 1ns/1ps
module test_hsl_lane_seq;

    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] t_lpx, t_prep, t_zero, t_trail, t_exit;
    logic          clk_ready, burst_req;
    logic [7:0]    tx_data;
    logic          tx_valid, tx_last, tx_ready;
    logic          lp_dp, lp_dn, hs_en, burst_done;
    logic [7:0]    hs_data;

    always #2.5 clk = ~clk;

    hsl_lane_seq #(.CNT_W(CW)) i_hsl_lane_seq (
        .clk(clk), .rst_n(rst_n),
        .t_lpx(t_lpx), .t_prep(t_prep), .t_zero(t_zero),
        .t_trail(t_trail), .t_exit(t_exit),
        .clk_ready(clk_ready), .burst_req(burst_req),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_ready(tx_ready),
        .lp_dp(lp_dp), .lp_dn(lp_dn), .hs_en(hs_en),
        .hs_data(hs_data), .burst_done(burst_done)
    );

    typedef struct packed {
        logic       dp;
        logic       dn;
        logic       hs;
        logic [7:0] d;
        logic       rdy;
        logic       done;
        logic [7:0] tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] plan_bytes[$];
    int         plan_len[$];
    logic [8:0] src_q[$];
    int         cur_len  = 0;
    int         compared = 0;
    int         mismatched = 0;
    int         started  = 0;
    int         idle_tag = 1;
    bit         idle_prev = 1'b1;
    bit         rdy_prev  = 1'b0;

    function automatic exp_t mk(logic dp, logic dn, logic hs, logic [7:0] d,
                                logic rdy, logic done, int tag);
        exp_t e;
        e.dp = dp; e.dn = dn; e.hs = hs; e.d = d;
        e.rdy = rdy; e.done = done; e.tag = 8'(tag);
        return e;
    endfunction

    // Intervals: 0 acts as one cycle (R11).
    task automatic push_n(int cfg, exp_t e, int tag);
        int n = (cfg == 0) ? 1 : cfg;
        e.tag = 8'((cfg == 0) ? 11 : tag);
        repeat (n) exp_q.push_back(e);
    endtask

    task automatic add_byte(logic [7:0] v, bit last);
        plan_bytes.push_back(v);
        src_q.push_back({last, v});
        cur_len++;
        if (last) begin plan_len.push_back(cur_len); cur_len = 0; end
    endtask

    task automatic start_burst();
        int         n = plan_len.pop_front();
        logic [7:0] last_b = 8'h00;
        push_n(int'(t_lpx),  mk(0, 1, 0, 8'h00, 0, 0, 0), 3);  // R3 LP-01
        push_n(int'(t_prep), mk(0, 0, 0, 8'h00, 0, 0, 0), 4);  // R4 LP-00
        push_n(int'(t_zero), mk(0, 0, 1, 8'h00, 0, 0, 0), 5);  // R5 HS zero
        exp_q.push_back(mk(0, 0, 1, 8'hB8, 1, 0, 6));          // R6 sync
        for (int i = 0; i < n; i++) begin                       // R7 payload
            last_b = plan_bytes.pop_front();
            exp_q.push_back(mk(0, 0, 1, last_b, (i < n - 1), 0, 7));
        end
        push_n(int'(t_trail), mk(0, 0, 1, {8{~last_b[7]}}, 0, 0, 0), 8); // R8
        push_n(1, mk(1, 1, 0, 8'h00, 0, 1, 0), 9);             // R9 done
        if (int'(t_exit) == 0) exp_q[$].tag = 8'd11;
        for (int i = 1; i < int'(t_exit); i++)                  // R10 hold
            exp_q.push_back(mk(1, 1, 0, 8'h00, 0, 0, 10));
    endtask

    task automatic compare(exp_t e);
        compared++;
        if (lp_dp !== e.dp || lp_dn !== e.dn || hs_en !== e.hs || hs_data !== e.d ||
            tx_ready !== e.rdy || burst_done !== e.done) begin
            mismatched++;
            $display("FAIL R%0d @%0t: got dp%b dn%b hs%b d%h rdy%b done%b, expected dp%b dn%b hs%b d%h rdy%b done%b",
                     e.tag, $time, lp_dp, lp_dn, hs_en, hs_data, tx_ready, burst_done,
                     e.dp, e.dn, e.hs, e.d, e.rdy, e.done);
        end
    endtask

    task automatic cycle();
        exp_t e;
        @(negedge clk);
        if (!rst_n) begin
            compare(mk(1, 1, 0, 8'h00, 0, 0, 1));   // R1 reset state
            idle_prev = 1'b1;
            rdy_prev  = 1'b0;
        end else begin
            if (rdy_prev && tx_valid && src_q.size() > 0) void'(src_q.pop_front());
            if (idle_prev && burst_req && clk_ready) begin
                start_burst();
                started++;
            end
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                idle_prev = 1'b0;
            end else begin
                e = mk(1, 1, 0, 8'h00, 0, 0, idle_tag);
                idle_prev = 1'b1;
            end
            compare(e);
            rdy_prev = tx_ready;
        end
        tx_valid = (src_q.size() > 0);
        tx_data  = (src_q.size() > 0) ? src_q[0][7:0] : 8'h00;
        tx_last  = (src_q.size() > 0) ? src_q[0][8] : 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        int target;
        rst_n = 1'b0; burst_req = 1'b0; clk_ready = 1'b0;
        tx_valid = 1'b0; tx_data = 8'h00; tx_last = 1'b0;
        t_lpx = 3; t_prep = 4; t_zero = 5; t_trail = 3; t_exit = 4;

        // R1: reset and quiet stop
        repeat (3) cycle();
        rst_n = 1'b1;
        idle_tag = 1;
        repeat (2) cycle();

        // R2: request without clock-lane readiness
        idle_tag = 2;
        burst_req = 1'b1;
        repeat (10) cycle();
        burst_req = 1'b0;
        cycle();

        // Burst A: four bytes, last has bit 7 set, trail 8'h00 (R3..R10)
        idle_tag = 10;
        add_byte(8'h11, 0); add_byte(8'hA5, 0); add_byte(8'h3C, 0); add_byte(8'hF0, 1);
        clk_ready = 1'b1;
        burst_req = 1'b1;
        cycle();
        burst_req = 1'b0;
        repeat (40) cycle();

        // Burst B: all intervals zero, single byte, trail 8'hFF (R11, R8)
        t_lpx = 0; t_prep = 0; t_zero = 0; t_trail = 0; t_exit = 0;
        add_byte(8'h42, 1);
        burst_req = 1'b1;
        cycle();
        burst_req = 1'b0;
        repeat (15) cycle();

        // Burst C: request held high across two bursts (R10 exit hold)
        t_lpx = 2; t_prep = 2; t_zero = 3; t_trail = 4; t_exit = 6;
        add_byte(8'h80, 0); add_byte(8'h01, 0); add_byte(8'h7E, 1);
        add_byte(8'hC3, 0); add_byte(8'h5A, 1);
        target = started + 2;
        burst_req = 1'b1;
        while (started < target) cycle();
        burst_req = 1'b0;
        repeat (50) cycle();

        // Readiness dropped after a burst: requests ignored again (R2)
        idle_tag = 2;
        clk_ready = 1'b0;
        add_byte(8'h99, 1);
        burst_req = 1'b1;
        repeat (8) cycle();
        burst_req = 1'b0;
        cycle();

        finish_run();
    end

endmodule